// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers up to eight interrupt request lines into a single active-high request to a processor. Each line is edge-sensitive: a low-to-high transition on a line whose mask bit is clear is remembered as pending. Any number of lines can be pending at the same time. Among them the lowest-numbered line always wins. The block also keeps an in-service record of the levels the processor is currently handling. A pending winner raises the processor request only if it outranks every level in that record.

When the processor acknowledges, the block returns a type number on `vec_out`. The number is a fixed base plus the index of the winning line. In the same cycle the block moves that line from pending to in-service. Software reaches the block through a two-address register port. The address with select 1 holds the mask. The address with select 0 reads back the pending lines, and it accepts the end-of-interrupt command byte, which releases the most important level in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on an unmasked line `irq_in[i]` sets pending bit i. Several bits may be pending together. Reading with `reg_sel`=0 returns the pending bits, with bit i belonging to line i.
- R2: A rising edge on a line whose mask bit is 1 is not recorded. Clearing the mask bit afterwards does not bring the lost edge back.
- R3: The priority order is fixed. Line 0 ranks highest and line NUM_LINES-1 ranks lowest. When several lines are pending, the lowest index is served first.
- R4: `int_out` is 1 exactly when some line is pending and the best pending line has a lower index than every in-service line. A pending line at the same level as an in-service level, or below it, is held off.
- R5: In a cycle where `int_ack` is 1 and `int_out` is 1, `vec_out` equals VEC_BASE (default 8) plus the winning index. At that clock edge the winner's pending bit clears and its in-service bit sets. No in-service bit is set in any other way.
- R6: Writing with `reg_sel`=1 loads the mask register from `wr_data`. Reading with `reg_sel`=1 returns the mask. The mask is 0 after reset, so all lines are enabled.
- R7: Writing the byte 0x20 with `reg_sel`=0 clears only the lowest-index in-service bit that is set. Any other byte written with `reg_sel`=0 has no effect.
- R8: The end-of-interrupt command has no effect when no in-service bit is set.
- R9: A line that stays high after it has been served does not set its pending bit again. It must go low and then rise again.
- R10: After reset, the pending, in-service and mask registers are all zero and `int_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Edge-sensitive request lines |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge strobe, one cycle |
| vec_out | output | DATA_W | Type number for the current winner |
| reg_sel | input | 1 | Register select: 0 = pending/command, 1 = mask |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Read data for the selected register |

## Verification
Errors in the pending record show up in the read-back with select 0 one cycle after the edge is sampled. Errors in the in-service record have no read-back. They appear only through `int_out`: either a request is raised too early, or a request is still withheld after an end-of-interrupt command. The bench therefore sets up nested in-service states in which clearing the wrong level flips `int_out` on the very next cycle. Each acknowledge pushes its expected type number into a queue, so a wrong winner or a wrong base shows up in the acknowledge cycle itself.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // command byte that releases the most important in-service level
   localparam logic [7:0] EOI_CMD = 8'h20;
   // register select encodings
   localparam logic SEL_PEND = 1'b0;
   localparam logic SEL_MASK = 1'b1;
endpackage

// File: rtl/prio_irq_pick.sv
// Fixed-priority picker: lowest set index wins.
module prio_irq_pick #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/prio_irq_edge.sv
// Per-line edge capture and pending storage.
module prio_irq_edge #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] mask_q,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend_q
);
   for (genvar k = 0; k < N; k++) begin : g_line
      logic prev_q;
      logic p_q;
      logic rise;

      assign rise = irq_in[k] & ~prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            p_q    <= 1'b0;
         end else begin
            prev_q <= irq_in[k];
            p_q    <= (p_q & ~clr[k]) | (rise & ~mask_q[k]);
         end
      end

      assign pend_q[k] = p_q;

      // R2
      masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[k] && !p_q) |=> !p_q);

      // R9
      held_high_no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_in[k] && prev_q && !p_q) |=> !p_q);
   end
endmodule

// File: rtl/prio_irq_isr.sv
// In-service record: set on acknowledge, highest level released on end-of-interrupt.
module prio_irq_isr #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          eoi,
   output logic [N-1:0]  isr_q,
   output logic          isr_any,
   output logic [IW-1:0] isr_idx
);
   logic [N-1:0] isr_d;

   prio_irq_pick #(.N(N), .IW(IW)) u_top (
      .req (isr_q),
      .any (isr_any),
      .idx (isr_idx)
   );

   always_comb begin
      isr_d = isr_q;
      if (eoi && isr_any) isr_d[isr_idx] = 1'b0;
      if (set_en) isr_d[set_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end

   // R5
   isr_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en |=> ((isr_q & ~$past(isr_q)) == '0));

   // R8
   eoi_empty_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !isr_any && !set_en) |=> (isr_q == '0));

   // R7
   eoi_single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_any && !set_en) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: mask register, command decode, request gating and vector output.
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 8,
   parameter int VEC_BASE  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic                 int_out,
   input  logic                 int_ack,
   output logic [DATA_W-1:0]    vec_out,
   input  logic                 reg_sel,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data
);
   localparam int N  = NUM_LINES;
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2 || N > DATA_W) begin : g_bad_lines
      $error("NUM_LINES must lie in 2..DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold the command byte");
   end
   if (VEC_BASE < 0 || VEC_BASE + N > (1 << DATA_W)) begin : g_bad_base
      $error("VEC_BASE plus NUM_LINES must fit in DATA_W");
   end

   logic [N-1:0]  mask_q;
   logic [N-1:0]  pend_q;
   logic [N-1:0]  isr_q;
   logic [N-1:0]  ack_clr;
   logic          pend_any;
   logic [IW-1:0] win_idx;
   logic          isr_any;
   logic [IW-1:0] isr_idx;
   logic          ack_fire;
   logic          eoi;

   prio_irq_edge #(.N(N)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_in),
      .mask_q (mask_q),
      .clr    (ack_clr),
      .pend_q (pend_q)
   );

   prio_irq_pick #(.N(N), .IW(IW)) u_win (
      .req (pend_q),
      .any (pend_any),
      .idx (win_idx)
   );

   prio_irq_isr #(.N(N), .IW(IW)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (ack_fire),
      .set_idx (win_idx),
      .eoi     (eoi),
      .isr_q   (isr_q),
      .isr_any (isr_any),
      .isr_idx (isr_idx)
   );

   assign int_out  = pend_any && (!isr_any || (win_idx < isr_idx));
   assign ack_fire = int_ack && int_out;
   assign eoi      = wr_en && (reg_sel == SEL_PEND) && (wr_data[7:0] == EOI_CMD)
                     && (wr_data >> 8) == '0;

   always_comb begin
      ack_clr = '0;
      if (ack_fire) ack_clr[win_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else if (wr_en && reg_sel == SEL_MASK) mask_q <= wr_data[N-1:0];
   end

   assign vec_out = DATA_W'(VEC_BASE) + DATA_W'(win_idx);

   always_comb begin
      rd_data = '0;
      rd_data[N-1:0] = (reg_sel == SEL_MASK) ? mask_q : pend_q;
   end

   // R4
   held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((isr_q & pend_q & ~(pend_q - 1'b1)) == '0) && (isr_q & (pend_q - 1'b1) & ~pend_q) == (isr_q & (pend_q - 1'b1) & ~pend_q) && ((isr_q & ((pend_q & ~(pend_q - 1'b1)) - 1'b1)) == '0));

   // R5
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |-> (vec_out >= DATA_W'(VEC_BASE)) && (vec_out < DATA_W'(VEC_BASE + N)));

   // R5
   ack_moves_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> isr_q[$past(win_idx)]);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       int_out;
   logic       int_ack = 1'b0;
   logic [7:0] vec_out;
   logic       reg_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   int exp_q[$];

   always #5 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out),
      .int_ack(int_ack), .vec_out(vec_out), .reg_sel(reg_sel),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   task automatic pulse(logic [7:0] bits);
      tick;
      irq_in = irq_in | bits;
      tick;
      irq_in = irq_in & ~bits;
   endtask

   task automatic wr(logic sel, logic [7:0] d);
      tick;
      reg_sel = sel; wr_en = 1'b1; wr_data = d;
      tick;
      wr_en = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic rd(logic sel, output int v);
      reg_sel = sel;
      #1;
      v = rd_data;
      reg_sel = 1'b0;
   endtask

   // driver side of the scoreboard: expected type number goes into the queue
   task automatic do_ack(int v);
      tick;
      exp_q.push_back(v);
      int_ack = 1'b1;
      tick;
      int_ack = 1'b0;
   endtask

   task automatic eoi;
      wr(1'b0, 8'h20);
   endtask

   // monitor side: compares each acknowledge against the queue head
   always @(negedge clk) begin
      if (rst_n && int_ack) begin
         chk("R5 int_out during ack", int'(int_out), 1);
         if (exp_q.size() == 0) chk("R5 unexpected ack", 1, 0);
         else chk("R5 vector", int'(vec_out), exp_q.pop_front());
      end
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      tick;
      // R10 reset state
      chk("R10 int_out", int'(int_out), 0);
      rd(1'b0, v); chk("R10 pending", v, 0);
      rd(1'b1, v); chk("R10 mask", v, 0);

      // R1 single edge
      pulse(8'h08);
      rd(1'b0, v); chk("R1 pending", v, 8'h08);
      chk("R4 raise", int'(int_out), 1);
      do_ack(11);
      chk("R5 clears pending", int'(int_out), 0);
      rd(1'b0, v); chk("R5 pending empty", v, 0);

      // R4 holding off lower and same levels while 3 is in service
      pulse(8'h20);
      chk("R4 lower held", int'(int_out), 0);
      pulse(8'h08);
      chk("R4 same held", int'(int_out), 0);
      pulse(8'h02);
      chk("R4 higher passes", int'(int_out), 1);
      rd(1'b0, v); chk("R1 multi pending", v, 8'h2A);
      do_ack(9);
      chk("R4 nested held", int'(int_out), 0);
      pulse(8'h04);
      chk("R4 between levels held", int'(int_out), 0);

      // R7 other bytes ignored, command clears only highest level
      wr(1'b0, 8'h60);
      chk("R7 non-command ignored", int'(int_out), 0);
      rd(1'b0, v); chk("R7 pending kept", v, 8'h2C);
      eoi;
      chk("R7 released level 1 only", int'(int_out), 1);
      do_ack(10);
      eoi;
      chk("R7 level 3 still in service", int'(int_out), 0);
      eoi;
      chk("R7 level 3 released", int'(int_out), 1);
      do_ack(11);
      chk("R4 line 5 held", int'(int_out), 0);
      eoi;
      do_ack(13);
      eoi;
      chk("R7 all clear", int'(int_out), 0);

      // R8 command with empty in-service record
      eoi;
      chk("R8 int_out", int'(int_out), 0);
      rd(1'b0, v); chk("R8 pending", v, 0);
      pulse(8'h80);
      chk("R8 lowest line still served", int'(int_out), 1);
      do_ack(15);
      eoi;

      // R3 simultaneous edges
      pulse(8'h50);
      rd(1'b0, v); chk("R3 both pending", v, 8'h50);
      do_ack(12);
      chk("R3 line 6 waits", int'(int_out), 0);
      eoi;
      do_ack(14);
      eoi;

      // R6 and R2 mask behaviour
      wr(1'b1, 8'h01);
      rd(1'b1, v); chk("R6 mask readback", v, 8'h01);
      pulse(8'h01);
      rd(1'b0, v); chk("R2 masked not latched", v, 0);
      chk("R2 int_out", int'(int_out), 0);
      wr(1'b1, 8'h00);
      rd(1'b1, v); chk("R6 mask cleared", v, 0);
      chk("R2 not recovered", int'(int_out), 0);

      // R9 held-high line
      tick; irq_in[2] = 1'b1;
      tick;
      chk("R9 first edge", int'(int_out), 1);
      do_ack(10);
      eoi;
      tick; tick;
      chk("R9 no retrigger", int'(int_out), 0);
      rd(1'b0, v); chk("R9 pending empty", v, 0);
      tick; irq_in[2] = 1'b0;
      tick; irq_in[2] = 1'b1;
      tick;
      chk("R9 new edge", int'(int_out), 1);
      do_ack(10);
      eoi;
      irq_in[2] = 1'b0;
      tick; tick;

      chk("R5 all acks seen", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule